// File: doc/BRIEF.md
# Maskable Time Alarm Comparator

This block sits beside a clock-calendar counter and raises a sticky alarm flag when the running time reaches a programmed moment. It holds four alarm registers: seconds, minutes, hours, and a shared day/date register. Each is written and read over a simple register bus. Once per second the counter pulses a compare strobe. On that pulse, every alarm field whose mask bit is clear must equal the matching live time field. When all of them match and the oscillator is enabled, the flag is set.

The top bit of each alarm register is a mask that turns its field into a don't-care. This sets how often the alarm repeats. With all four masks set, it fires every second. Clearing the masks from seconds upward gives one alarm per minute, per hour, per day, and finally per week or per month. In the fourth register a select bit decides whether that register is compared with the day of the week or with the date. The flag stays set until software pulses the clear input.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset all four alarm registers read 00h and the alarm flag is 0.
- R2: A write sets the register at the given address to all 8 data bits, and a read returns it from the next cycle on. Addresses: 0 is seconds, 1 is minutes, 2 is hours, 3 is day/date.
- R3: In the seconds, minutes and hours registers, when bit 7 is 0, bits 6:0 must equal the 7-bit live seconds, minutes or hours input for the field to match.
- R4: Bit 7 set to 1 in any alarm register makes that field match whatever the live value is.
- R5: In the day/date register, when bit 7 is 0, bit 6 selects the target of the compare. If bit 6 is 1, bits 5:0 are compared with the day-of-week input zero-extended to 6 bits. If bit 6 is 0, bits 5:0 are compared with the 6-bit date input.
- R6: A compare happens only in a cycle where the second strobe is high. On a full match the flag is 1 at the next clock edge. Without the strobe the flag never rises.
- R7: While the oscillator-enable input is 0, a strobe with a full match does not set the flag.
- R8: Once set, the flag stays at 1 until a cycle with the clear input high. It is then 0 after that edge, unless R9 applies.
- R9: A clear in the same cycle as a strobe with a full match leaves the flag at 1.
- R10: With all four mask bits set, every enabled strobe sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Contents of the addressed register |
| sec_tick | input | 1 | One-cycle strobe once per second, after the time update |
| osc_en | input | 1 | Oscillator running; alarms are blocked when 0 |
| live_sec | input | 7 | Current seconds (BCD) |
| live_min | input | 7 | Current minutes (BCD) |
| live_hour | input | 7 | Current hours, with mode bits |
| live_dow | input | 3 | Current day of week |
| live_date | input | 6 | Current date (BCD) |
| flag_clr | input | 1 | Clear request for the alarm flag |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The read port is combinational from the registers. A value written in one cycle is therefore due on rd_data after the edge that closes that cycle. The flag is due after the edge that closes the strobe cycle. A clear likewise takes effect at the edge that ends its cycle. The bench drives every input on the falling edge and compares outputs on the next falling edge, half a period after the only register update those outputs depend on. Its model computes the flag from the registers as they stood before that cycle's write, which matches the hardware order.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ALM_FIELDS = 4;
  localparam int ALM_DATA_W = 8;
  localparam int ALM_ADDR_W = 2;
  localparam int ALM_TIME_W = 7;
  localparam int ALM_DD_W   = 6;
  localparam int ALM_DOW_W  = 3;

  localparam int MASK_BIT   = 7;
  localparam int DSEL_BIT   = 6;

  typedef enum logic [ALM_ADDR_W-1:0] {
    SLOT_SEC     = 2'd0,
    SLOT_MIN     = 2'd1,
    SLOT_HOUR    = 2'd2,
    SLOT_DAYDATE = 2'd3
  } alm_slot_e;

  typedef logic [ALM_FIELDS-1:0][ALM_DATA_W-1:0] alm_regs_t;
endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/alm_regfile.sv
module alm_regfile
  import alm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ALM_ADDR_W-1:0] wr_addr,
  input  logic [ALM_DATA_W-1:0] wr_data,
  input  logic [ALM_ADDR_W-1:0] rd_addr,
  output logic [ALM_DATA_W-1:0] rd_data,
  output alm_regs_t             regs
);
  alm_regs_t regs_q;
  alm_regs_t regs_d;
  logic [ALM_FIELDS-1:0] reg_en;

  for (genvar g = 0; g < ALM_FIELDS; g++) begin : g_slot
    always_comb begin
      reg_en[g] = wr_en && (wr_addr == ALM_ADDR_W'(g));
      regs_d[g] = reg_en[g] ? wr_data : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[g] <= '0;
      else if (reg_en[g]) regs_q[g] <= regs_d[g];
    end
  end

  always_comb begin
    rd_data = regs_q[rd_addr];
  end

  assign regs = regs_q;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_q[$past(wr_addr)] == $past(wr_data)));

  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/alm_cmp.sv
module alm_cmp
  import alm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  alm_regs_t             regs,
  input  logic [ALM_TIME_W-1:0] live_sec,
  input  logic [ALM_TIME_W-1:0] live_min,
  input  logic [ALM_TIME_W-1:0] live_hour,
  input  logic [ALM_DOW_W-1:0]  live_dow,
  input  logic [ALM_DD_W-1:0]   live_date,
  output logic                  match
);
  localparam int TIME_FIELDS = ALM_FIELDS - 1;

  logic [TIME_FIELDS-1:0][ALM_TIME_W-1:0] live_time;
  logic [ALM_FIELDS-1:0] field_ok;
  logic [ALM_DD_W-1:0]   dd_target;
  logic [ALM_DATA_W-1:0] dd_reg;

  always_comb begin
    live_time[SLOT_SEC]  = live_sec;
    live_time[SLOT_MIN]  = live_min;
    live_time[SLOT_HOUR] = live_hour;
  end

  for (genvar g = 0; g < TIME_FIELDS; g++) begin : g_time
    always_comb begin
      field_ok[g] = regs[g][MASK_BIT] ||
                    (regs[g][ALM_TIME_W-1:0] == live_time[g]);
    end
  end

  always_comb begin
    dd_reg    = regs[SLOT_DAYDATE];
    dd_target = dd_reg[DSEL_BIT] ? ALM_DD_W'(live_dow) : live_date;
    field_ok[SLOT_DAYDATE] = dd_reg[MASK_BIT] ||
                             (dd_reg[ALM_DD_W-1:0] == dd_target);
  end

  assign match = &field_ok;

  assert_all_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[0][MASK_BIT] && regs[1][MASK_BIT] && regs[2][MASK_BIT] &&
     regs[3][MASK_BIT]) |-> match);

  assert_sec_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!regs[SLOT_SEC][MASK_BIT] && (regs[SLOT_SEC][ALM_TIME_W-1:0] != live_sec))
      |-> !match);
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic osc_en,
  input  logic match,
  input  logic flag_clr,
  output logic hit,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    hit     = sec_tick && osc_en && match;
    flag_en = hit || flag_clr;
    flag_d  = hit ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_rise_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(flag_q));

  assert_osc_off_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !$rose(flag_q));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit) |=> !flag_q);

  assert_hit_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import alm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ALM_ADDR_W-1:0] wr_addr,
  input  logic [ALM_DATA_W-1:0] wr_data,
  input  logic [ALM_ADDR_W-1:0] rd_addr,
  output logic [ALM_DATA_W-1:0] rd_data,
  input  logic                  sec_tick,
  input  logic                  osc_en,
  input  logic [ALM_TIME_W-1:0] live_sec,
  input  logic [ALM_TIME_W-1:0] live_min,
  input  logic [ALM_TIME_W-1:0] live_hour,
  input  logic [ALM_DOW_W-1:0]  live_dow,
  input  logic [ALM_DD_W-1:0]   live_date,
  input  logic                  flag_clr,
  output logic                  alarm_flag
);
  logic      rst_n_s;
  alm_regs_t regs;
  logic      match;
  logic      hit;

  alm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  alm_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .regs    (regs)
  );

  alm_cmp u_cmp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .regs      (regs),
    .live_sec  (live_sec),
    .live_min  (live_min),
    .live_hour (live_hour),
    .live_dow  (live_dow),
    .live_date (live_date),
    .match     (match)
  );

  alm_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sec_tick (sec_tick),
    .osc_en   (osc_en),
    .match    (match),
    .flag_clr (flag_clr),
    .hit      (hit),
    .flag     (alarm_flag)
  );

  assert_dd_select_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!regs[SLOT_DAYDATE][MASK_BIT] && regs[SLOT_DAYDATE][DSEL_BIT] &&
     (regs[SLOT_DAYDATE][ALM_DD_W-1:0] != ALM_DD_W'(live_dow))) |-> !match);

  assert_mask_sec_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sec_tick && osc_en && regs[0][MASK_BIT] && regs[1][MASK_BIT] &&
     regs[2][MASK_BIT] && regs[3][MASK_BIT]) |=> alarm_flag);
endmodule

// File: tb/sim_rtc_alarm_match.sv
module sim_rtc_alarm_match;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       sec_tick;
  logic       osc_en;
  logic [6:0] live_sec, live_min, live_hour;
  logic [2:0] live_dow;
  logic [5:0] live_date;
  logic       flag_clr;
  logic       alarm_flag;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_reg [4];
  logic       m_flag;

  always #5 clk = ~clk;

  rtc_alarm_match u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_tick(sec_tick), .osc_en(osc_en), .live_sec(live_sec),
    .live_min(live_min), .live_hour(live_hour), .live_dow(live_dow),
    .live_date(live_date), .flag_clr(flag_clr), .alarm_flag(alarm_flag)
  );

  function automatic logic model_match();
    logic ok;
    logic [5:0] tgt;
    ok = 1'b1;
    if (!m_reg[0][7] && m_reg[0][6:0] != live_sec)  ok = 1'b0;
    if (!m_reg[1][7] && m_reg[1][6:0] != live_min)  ok = 1'b0;
    if (!m_reg[2][7] && m_reg[2][6:0] != live_hour) ok = 1'b0;
    tgt = m_reg[3][6] ? {3'b000, live_dow} : live_date;
    if (!m_reg[3][7] && m_reg[3][5:0] != tgt) ok = 1'b0;
    return ok;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    sec_tick = 0; flag_clr = 0;
  endtask

  // One clock: inputs already driven; update model, pass the edge, sample at negedge.
  task automatic cycle(input string req);
    logic hit;
    hit = sec_tick && osc_en && model_match();
    m_flag = hit | (m_flag & ~flag_clr);
    if (wr_en) m_reg[wr_addr] = wr_data;
    @(negedge clk);
    check(req, {7'd0, alarm_flag}, {7'd0, m_flag});
    check("R2", rd_data, m_reg[rd_addr]);
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; rd_addr = a;
    cycle("R2");
  endtask

  task automatic set_time(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                          input logic [2:0] dw, input logic [5:0] dt);
    live_sec = s; live_min = m; live_hour = h; live_dow = dw; live_date = dt;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); osc_en = 1;
    set_time(0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      rd_addr = 2'(i);
      #1 check("R1", rd_data, 8'h00);
    end
    check("R1", {7'd0, alarm_flag}, 8'h00);

    // R3: exact sec/min/hour/date match
    wr(0, 8'h45); wr(1, 8'h30); wr(2, 8'h12); wr(3, 8'h15);
    set_time(7'h45, 7'h30, 7'h12, 3'd2, 6'h15);
    sec_tick = 1; cycle("R3");
    check("R3", {7'd0, alarm_flag}, 8'h01);
    // R8: sticky without clear
    cycle("R8");
    sec_tick = 1; set_time(7'h46, 7'h30, 7'h12, 3'd2, 6'h15); cycle("R8");
    check("R8", {7'd0, alarm_flag}, 8'h01);
    flag_clr = 1; cycle("R8");
    check("R8", {7'd0, alarm_flag}, 8'h00);
    // R3: one-off hour mismatch
    set_time(7'h45, 7'h30, 7'h13, 3'd2, 6'h15);
    sec_tick = 1; cycle("R3");
    check("R3", {7'd0, alarm_flag}, 8'h00);
    // R6: match without strobe
    set_time(7'h45, 7'h30, 7'h12, 3'd2, 6'h15);
    cycle("R6");
    check("R6", {7'd0, alarm_flag}, 8'h00);
    // R7: oscillator off
    osc_en = 0; sec_tick = 1; cycle("R7");
    check("R7", {7'd0, alarm_flag}, 8'h00);
    osc_en = 1;
    // R5: day-of-week select, date differs
    wr(3, 8'h45);
    set_time(7'h45, 7'h30, 7'h12, 3'd5, 6'h20);
    sec_tick = 1; cycle("R5");
    check("R5", {7'd0, alarm_flag}, 8'h01);
    flag_clr = 1; cycle("R8");
    set_time(7'h45, 7'h30, 7'h12, 3'd4, 6'h05);
    sec_tick = 1; cycle("R5");
    check("R5", {7'd0, alarm_flag}, 8'h00);
    // R4: mask seconds and minutes -> fires on any sec/min
    wr(0, 8'h80); wr(1, 8'h80);
    set_time(7'h59, 7'h01, 7'h12, 3'd5, 6'h00);
    sec_tick = 1; cycle("R4");
    check("R4", {7'd0, alarm_flag}, 8'h01);
    // R9: clear together with a hit
    flag_clr = 1; sec_tick = 1; cycle("R9");
    check("R9", {7'd0, alarm_flag}, 8'h01);
    flag_clr = 1; cycle("R8");
    // R10: all masked
    wr(2, 8'hFF); wr(3, 8'h80);
    set_time(7'h11, 7'h22, 7'h33, 3'd1, 6'h09);
    sec_tick = 1; cycle("R10");
    check("R10", {7'd0, alarm_flag}, 8'h01);

    // Random phase against the model
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      wr_en    = ($urandom % 4) == 0;
      wr_addr  = 2'($urandom);
      wr_data  = 8'($urandom);
      rd_addr  = 2'($urandom);
      sec_tick = ($urandom % 3) == 0;
      osc_en   = ($urandom % 8) != 0;
      flag_clr = ($urandom % 5) == 0;
      if ($urandom % 2) begin
        set_time(m_reg[0][6:0], m_reg[1][6:0], m_reg[2][6:0],
                 m_reg[3][2:0], m_reg[3][5:0]);
        if ($urandom % 3 == 0) live_min = 7'($urandom);
      end else begin
        set_time(7'($urandom), 7'($urandom), 7'($urandom), 3'($urandom), 6'($urandom));
      end
      cycle("R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule